// File: doc/BRIEF.md
# Piecewise-linear sigmoid activation unit

This unit approximates the logistic sigmoid for one fixed-point sample at a time. Input and output words are 16-bit two's-complement integers that hold a real value multiplied by 1024, with the fractional part dropped. An output code of 1024 stands for 1.0.

The unit first takes the magnitude of the argument. Three comparators against breakpoints at 1.0, 2.375 and 5.0 then pick one of four straight-line segments. Each slope is a right shift of the magnitude followed by the addition of a constant offset. A negative argument is handled by evaluating the curve at its magnitude and subtracting the result from 1.0. The unit is a two-register pipeline. The input side has a valid/ready handshake. The output register holds its value while the consumer stalls, and the whole pipe advances as one.

Top module: `sig_pwl_unit`

## Requirements
- R1: `data_o` is a 16-bit two's-complement word scaled by 1024 and always lies in the range 0 to 1024 while `valid_o` is high.
- R2: For a magnitude m below 1024, the positive-side value is (m >> 2) + 512.
- R3: For m from 1024 to 2431 inclusive, the positive-side value is (m >> 3) + 640.
- R4: For m from 2432 to 5119 inclusive, the positive-side value is (m >> 5) + 864.
- R5: For m of 5120 or more, the positive-side value is 1024.
- R6: For a negative input x, the result is 1024 minus the positive-side value at m = -x.
- R7: The input code -32768 is treated as -32767, so the result is 0.
- R8: An input accepted on rising edge n (`valid_i` and `ready_o` both high) appears on `data_o`, with `valid_o` high, right after rising edge n+1, provided the output is not stalled.
- R9: While `valid_o` is high and `ready_i` is low, `ready_o` is low, and `valid_o` and `data_o` keep their values.
- R10: An active-low asynchronous reset `rst_ni` clears `valid_o`, `data_o` and the internal stage.
- R11: While `ready_i` is held high, a new input is accepted on every cycle and one result leaves on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is present |
| ready_o | output | 1 | Unit can take a sample this cycle |
| data_i | input | 16 | Argument, two's complement, scaled by 1024 |
| valid_o | output | 1 | Result is present |
| ready_i | input | 1 | Consumer takes the result this cycle |
| data_o | output | 16 | Sigmoid approximation, scaled by 1024 |

## Verification
A sample accepted on one rising edge is due on the outputs right after the next rising edge. When the consumer stalls, the sample's progress through the pipe is delayed one edge for each stalled edge. The bench keeps its own cycle model of the two stages, which it steps from the handshake values it samples at every falling edge. At that same falling edge it compares `valid_o`, `ready_o` and `data_o` against the model, so every result is checked in exactly the cycle it is due. The directed patterns cover both sides of each breakpoint, the extremes of the input range and a mid-run reset. The random phase toggles `ready_i` to exercise holding under backpressure.

// File: rtl/sig_pkg.sv
package sig_pkg;

  localparam int NUM_SEG = 4;
  localparam int NUM_BP  = NUM_SEG - 1;

  // breakpoints 1.0, 2.375, 5.0
  function automatic int bp_code(int idx, int frac);
    case (idx)
      0:       return 1 << frac;
      1:       return (2 << frac) + (3 << (frac - 3));
      default: return 5 << frac;
    endcase
  endfunction

  // slopes 1/4, 1/8, 1/32
  function automatic int seg_shift(int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      default: return 5;
    endcase
  endfunction

  // offsets 0.5, 0.625, 0.84375
  function automatic int seg_offset(int idx, int frac);
    case (idx)
      0:       return 1 << (frac - 1);
      1:       return 5 << (frac - 3);
      default: return 27 << (frac - 5);
    endcase
  endfunction

endpackage

// File: rtl/sig_fold.sv
module sig_fold #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] mag_o,
  output logic              neg_o
);
  localparam logic [DATA_W-1:0] MIN_C = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] x_sat;

  always_comb begin
    x_sat = (x_i == MIN_C) ? MIN_C + DATA_W'(1) : x_i;
    neg_o = x_sat[DATA_W-1];
    mag_o = neg_o ? DATA_W'(-x_sat) : x_sat;
  end

  always_comb begin
    if (!$isunknown(x_i))
      a_r7_no_overflow: assert (!mag_o[DATA_W-1]);
  end

endmodule

// File: rtl/sig_seg_sel.sv
module sig_seg_sel
  import sig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10,
  parameter int SEG_W  = 2
) (
  input  logic [DATA_W-1:0] mag_i,
  output logic [SEG_W-1:0]  seg_o
);
  logic [NUM_BP-1:0] above;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    assign above[g] = mag_i >= DATA_W'(bp_code(g, FRAC_W));
  end

  always_comb begin
    seg_o = '0;
    for (int i = 0; i < NUM_BP; i++) seg_o = seg_o + SEG_W'(above[i]);
  end

  // comparator outputs must form a thermometer code
  always_comb begin
    if (!$isunknown(above))
      for (int i = 0; i < NUM_BP - 1; i++)
        a_r4_bp_order: assert (!above[i+1] || above[i]);
  end

endmodule

// File: rtl/sig_seg_eval.sv
module sig_seg_eval
  import sig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10,
  parameter int SEG_W  = 2
) (
  input  logic [DATA_W-1:0] mag_i,
  input  logic              neg_i,
  input  logic [SEG_W-1:0]  seg_i,
  output logic [DATA_W-1:0] y_o
);
  localparam logic [DATA_W-1:0] ONE_C = DATA_W'(1) << FRAC_W;

  logic [DATA_W-1:0] seg_val [NUM_SEG];
  logic [DATA_W-1:0] pos;

  for (genvar g = 0; g < NUM_SEG - 1; g++) begin : g_seg
    assign seg_val[g] = (mag_i >> seg_shift(g)) + DATA_W'(seg_offset(g, FRAC_W));
  end
  assign seg_val[NUM_SEG-1] = ONE_C;

  always_comb begin
    pos = seg_val[seg_i];
    if (pos > ONE_C) pos = ONE_C;
    y_o = neg_i ? ONE_C - pos : pos;
  end

endmodule

// File: rtl/sig_pwl_unit.sv
module sig_pwl_unit
  import sig_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int SEG_W = $clog2(NUM_SEG);
  localparam logic [DATA_W-1:0] ONE_C = DATA_W'(1) << FRAC_W;

  logic [DATA_W-1:0] mag_d, s1_mag, y_d;
  logic              neg_d, s1_neg, s1_v, stall;
  logic [SEG_W-1:0]  seg_d, s1_seg;

  sig_fold #(.DATA_W(DATA_W)) u_fold (
    .x_i(data_i), .mag_o(mag_d), .neg_o(neg_d)
  );

  sig_seg_sel #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SEG_W(SEG_W)) u_sel (
    .mag_i(mag_d), .seg_o(seg_d)
  );

  assign stall   = valid_o && !ready_i;
  assign ready_o = !stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_mag <= '0;
      s1_neg <= 1'b0;
      s1_seg <= '0;
    end else if (!stall) begin
      s1_v <= valid_i;
      if (valid_i) begin
        s1_mag <= mag_d;
        s1_neg <= neg_d;
        s1_seg <= seg_d;
      end
    end
  end

  sig_seg_eval #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .SEG_W(SEG_W)) u_eval (
    .mag_i(s1_mag), .neg_i(s1_neg), .seg_i(s1_seg), .y_o(y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!stall) begin
      valid_o <= s1_v;
      if (s1_v) data_o <= y_d;
    end
  end

  a_r1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (data_o <= ONE_C));

  a_r8_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v && ready_o |=> valid_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

endmodule

// File: tb/sig_pwl_unit_bench.sv
module sig_pwl_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_i = 1'b1;
  logic [15:0] data_i = '0;
  logic        ready_o, valid_o;
  logic [15:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sig_pwl_unit u_sig_pwl_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .data_i(data_i), .valid_o(valid_o), .ready_i(ready_i), .data_o(data_o)
  );

  function automatic int ref_sig(logic [15:0] w);
    int x, m, p;
    x = int'($signed(w));
    if (x == -32768) x = -32767;
    m = (x < 0) ? -x : x;
    if (m < 1024)      p = (m >> 2) + 512;
    else if (m < 2432) p = (m >> 3) + 640;
    else if (m < 5120) p = (m >> 5) + 864;
    else               p = 1024;
    return (x < 0) ? 1024 - p : p;
  endfunction

  function automatic string ref_tag(logic [15:0] w);
    int x, m;
    x = int'($signed(w));
    if (x == -32768) return "R7";
    if (x < 0) return "R6";
    m = x;
    if (m < 1024) return "R2";
    if (m < 2432) return "R3";
    if (m < 5120) return "R4";
    return "R5";
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // cycle model of the two stages
  bit    m_s1_v = 0, m_out_v = 0, m_prev_stall = 0;
  int    m_s1_y = 0, m_out_y = 0;
  string m_s1_t = "", m_out_t = "";

  always @(negedge clk_i) begin
    bit stl;
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
    if (!rst_ni) begin
      chk("R10 valid_o", int'(valid_o), 0);
      chk("R10 data_o", int'(data_o), 0);
      m_s1_v = 0; m_out_v = 0; m_out_y = 0; m_prev_stall = 0;
    end else begin
      stl = m_out_v && !ready_i;
      chk("R8 R11 valid_o", int'(valid_o), int'(m_out_v));
      chk("R9 ready_o", int'(ready_o), int'(!stl));
      if (m_out_v) begin
        chk(m_out_t, int'(data_o), m_out_y);
        if (m_prev_stall) chk("R9 held", int'(data_o), m_out_y);
        chk("R1 range", int'(data_o <= 16'd1024), 1);
      end
      m_prev_stall = stl;
      if (!stl) begin
        m_out_v = m_s1_v;
        if (m_s1_v) begin m_out_y = m_s1_y; m_out_t = m_s1_t; end
        m_s1_v = valid_i;
        if (valid_i) begin m_s1_y = ref_sig(data_i); m_s1_t = ref_tag(data_i); end
      end
    end
  end

  task automatic drive(bit v, logic [15:0] d, bit r);
    @(posedge clk_i); #1;
    valid_i = v; data_i = d; ready_i = r;
  endtask

  initial begin
    int dir [] = '{0, 1, 1023, 1024, 1025, 2431, 2432, 2433, 5119, 5120, 32767,
                   -1, -1023, -1024, -2431, -2432, -5119, -5120, -32767, -32768,
                   700, -3000, 4000, -1500};
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // back-to-back accepts with ready_i high (R11)
    foreach (dir[i]) drive(1'b1, 16'(dir[i]), 1'b1);
    drive(1'b0, '0, 1'b1);
    // stall with full pipe (R9)
    drive(1'b1, 16'(1500), 1'b0);
    drive(1'b1, 16'(-700), 1'b0);
    drive(1'b1, 16'(6000), 1'b0);
    drive(1'b1, 16'(6000), 1'b1);
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b1);
    // mid-run reset (R10)
    drive(1'b1, 16'(300), 1'b1);
    @(posedge clk_i); #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] d;
      d = (k % 3 == 0) ? 16'($urandom_range(0, 12000)) - 16'd6000 : 16'($urandom);
      drive(1'($urandom_range(0, 3) != 0), d, 1'($urandom_range(0, 2) != 0));
    end
    repeat (4) drive(1'b0, '0, 1'b1);
    @(posedge clk_i);
    done = 1'b1;
    @(negedge clk_i);
    summary();
  end

endmodule